// File: doc/BRIEF.md
# SDRAM Open-Row Command Sequencer

This block turns single read or write requests, each carrying a bank, a row, a column and a direction, into a stream of SDRAM commands. It keeps a table of the open row in each of four banks, and rows stay open after each access. A request whose row is already open goes straight to READ or WRITE. A request to an idle bank first gets an ACTIVE. A request to a bank that holds a different row first gets a PRECHARGE of that bank and then an ACTIVE. Rows open in the other banks are never disturbed.

An internal interval counter raises a refresh request at a fixed period. When the sequencer is between requests and a refresh is pending, it issues PRECHARGE-ALL, waits the precharge time, issues AUTO-REFRESH and then waits the refresh time. No request is accepted during this sequence, and it leaves every bank closed. Requests enter through a valid/ready port. Commands leave as a strobe with a 3-bit code, a bank field and an address field. A one-cycle done pulse marks the completion of each request. The data path, power-up initialization and mode programming belong to other blocks.

Top module: `sdram_row_seq`

## Requirements
- R1: A READ or WRITE is issued only to a bank that holds an open row, and an ACTIVE is issued only to a bank that holds none.
- R2: On a row hit (bank open with the requested row), the only command for the request is READ (code 2) or WRITE (code 3), and it appears in the first cycle after the request is accepted.
- R3: On a request to a closed bank, ACTIVE (code 1) appears in the first cycle after acceptance with the row on the address field. READ or WRITE follows exactly T_RCD cycles after the ACTIVE, with the column zero-extended on the address field.
- R4: On a row miss, PRECHARGE (code 4) of that bank appears in the first cycle after acceptance. ACTIVE follows exactly T_RP cycles later, and READ/WRITE follows T_RCD cycles after that.
- R5: Opening or replacing a row in one bank leaves the open rows of all other banks unchanged, so a later access to them is a hit.
- R6: done is a one-cycle pulse in the cycle right after the READ or WRITE of the request.
- R7: A refresh becomes due every REF_INTERVAL cycles. It is served by PRECHARGE-ALL (code 5) followed exactly T_RP cycles later by AUTO-REFRESH (code 6), and afterwards every bank is closed. When the sequencer is idle, consecutive PRECHARGE-ALL commands are REF_INTERVAL cycles apart.
- R8: From PRECHARGE-ALL until T_RFC cycles after AUTO-REFRESH, req_ready is low and no other command is issued. req_ready returns high exactly T_RFC cycles after AUTO-REFRESH.
- R9: A request already accepted runs to completion before a pending refresh starts. A pending refresh is served before any waiting request is accepted.
- R10: Only one command is emitted per cycle. In cycles with no command, cmd_valid is low and cmd_code is NOP (code 0), and while req_ready is high no command is emitted.
- R11: During and right after reset, req_ready is high, cmd_valid and done are low, and all banks are closed.
- R12: The bank field is 2 bits, the row field 13 bits and the column field 10 bits. Row 8191 and column 1023 reach the address field intact.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | 2 | Target bank |
| req_row | input | 13 | Target row |
| req_col | input | 10 | Target column |
| cmd_valid | output | 1 | A command is driven this cycle |
| cmd_code | output | 3 | 0 NOP, 1 ACTIVE, 2 READ, 3 WRITE, 4 PRECHARGE, 5 PRECHARGE-ALL, 6 AUTO-REFRESH |
| cmd_bank | output | 2 | Bank of the command |
| cmd_addr | output | 13 | Row for ACTIVE, column for READ/WRITE, zero otherwise |
| done | output | 1 | One-cycle pulse when a request completes |

## Verification
A refresh becoming due and a request in flight can meet in the same cycle. Two cases are staged by timing requests against the measured refresh period. In the first, a request is accepted two cycles before the refresh falls due. It must complete its ACTIVE and READ undisturbed, and PRECHARGE-ALL must then appear in the cycle after its done. In the second, the request is presented in the very cycle the refresh becomes pending. It must be held off until T_RFC after AUTO-REFRESH, and must then open its row again because the refresh closed every bank.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

  typedef enum logic [2:0] {
    CMD_NOP  = 3'd0,
    CMD_ACT  = 3'd1,
    CMD_RD   = 3'd2,
    CMD_WR   = 3'd3,
    CMD_PRE  = 3'd4,
    CMD_PREA = 3'd5,
    CMD_REF  = 3'd6
  } cmd_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_PRE,
    S_ACT,
    S_RW,
    S_PREA,
    S_REF,
    S_WAIT
  } seq_state_e;

endpackage

// File: rtl/sdram_ref_timer.sv
module sdram_ref_timer #(
  parameter int INTERVAL = 780
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_taken,
  output logic ref_pending
);

  localparam int CW = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;
  localparam logic [CW-1:0] RELOAD = CW'(INTERVAL - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          pend_d;
  logic          tick;

  // free-running period counter; a new tick wins over a same-cycle take
  always_comb begin
    tick   = (cnt_q == '0);
    cnt_d  = tick ? RELOAD : cnt_q - 1'b1;
    pend_d = ref_pending;
    if (ref_taken) pend_d = 1'b0;
    if (tick)      pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q       <= RELOAD;
      ref_pending <= 1'b0;
    end else begin
      cnt_q       <= cnt_d;
      ref_pending <= pend_d;
    end
  end

endmodule

// File: rtl/sdram_bank_table.sv
module sdram_bank_table #(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 13,
  parameter int BANK_W    = $clog2(NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              open_en,
  input  logic [BANK_W-1:0] open_bank,
  input  logic [ROW_W-1:0]  open_row,
  input  logic              close_en,
  input  logic [BANK_W-1:0] close_bank,
  input  logic              close_all,
  input  logic [BANK_W-1:0] look_bank,
  input  logic [ROW_W-1:0]  look_row,
  output logic              look_open,
  output logic              look_hit
);

  logic [NUM_BANKS-1:0] open_vec;
  logic [ROW_W-1:0]     row_arr [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic             set_b, clr_b;
    logic             open_b;
    logic [ROW_W-1:0] row_b;

    assign set_b = open_en && (open_bank == BANK_W'(b));
    assign clr_b = close_all || (close_en && (close_bank == BANK_W'(b)));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     open_b <= 1'b0;
      else if (set_b) open_b <= 1'b1;
      else if (clr_b) open_b <= 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     row_b <= '0;
      else if (set_b) row_b <= open_row;
    end

    assign open_vec[b] = open_b;
    assign row_arr[b]  = row_b;
  end

  assign look_open = open_vec[look_bank];
  assign look_hit  = look_open && (row_arr[look_bank] == look_row);

endmodule

// File: rtl/sdram_delay_cnt.sv
module sdram_delay_cnt #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)               cnt_d = load_val;
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/sdram_row_seq.sv
module sdram_row_seq
  import sdram_seq_pkg::*;
#(
  parameter int NUM_BANKS    = 4,
  parameter int ROW_W        = 13,
  parameter int COL_W        = 10,
  parameter int T_RP         = 3,
  parameter int T_RCD        = 3,
  parameter int T_RFC        = 8,
  parameter int REF_INTERVAL = 780,
  localparam int BANK_W      = $clog2(NUM_BANKS),
  localparam int ADDR_W      = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  output logic              cmd_valid,
  output logic [2:0]        cmd_code,
  output logic [BANK_W-1:0] cmd_bank,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              done
);

  localparam int DMAX0 = (T_RP > T_RCD) ? T_RP : T_RCD;
  localparam int DMAX  = (DMAX0 > T_RFC) ? DMAX0 : T_RFC;
  localparam int DCW   = (DMAX > 2) ? $clog2(DMAX) : 1;

  function automatic logic [DCW-1:0] wait_load(input int d);
    return (d >= 2) ? DCW'(d - 2) : '0;
  endfunction

  seq_state_e state_q, state_d, ret_q, ret_d;
  logic              lat_en;
  logic              wr_q;
  logic [BANK_W-1:0] bank_q;
  logic [ROW_W-1:0]  row_q;
  logic [COL_W-1:0]  col_q;
  logic              done_q;
  logic              dly_load, dly_expired;
  logic [DCW-1:0]    dly_val;
  logic              look_open, look_hit;
  logic              ref_pending;
  cmd_e              cmd_d;

  sdram_ref_timer #(.INTERVAL(REF_INTERVAL)) u_ref (
    .clk        (clk),
    .rst_n      (rst_n),
    .ref_taken  (state_q == S_REF),
    .ref_pending(ref_pending)
  );

  sdram_bank_table #(.NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W), .BANK_W(BANK_W)) u_tbl (
    .clk       (clk),
    .rst_n     (rst_n),
    .open_en   (state_q == S_ACT),
    .open_bank (bank_q),
    .open_row  (row_q),
    .close_en  (state_q == S_PRE),
    .close_bank(bank_q),
    .close_all (state_q == S_PREA),
    .look_bank (req_bank),
    .look_row  (req_row),
    .look_open (look_open),
    .look_hit  (look_hit)
  );

  sdram_delay_cnt #(.CW(DCW)) u_dly (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (dly_load),
    .load_val(dly_val),
    .expired (dly_expired)
  );

  // next-state logic
  always_comb begin
    state_d  = state_q;
    ret_d    = ret_q;
    lat_en   = 1'b0;
    dly_load = 1'b0;
    dly_val  = '0;
    unique case (state_q)
      S_IDLE: begin
        if (ref_pending) begin
          state_d = S_PREA;
        end else if (req_valid) begin
          lat_en = 1'b1;
          if (look_hit)       state_d = S_RW;
          else if (look_open) state_d = S_PRE;
          else                state_d = S_ACT;
        end
      end
      S_PRE: begin
        dly_load = 1'b1;
        dly_val  = wait_load(T_RP);
        ret_d    = S_ACT;
        state_d  = (T_RP > 1) ? S_WAIT : S_ACT;
      end
      S_ACT: begin
        dly_load = 1'b1;
        dly_val  = wait_load(T_RCD);
        ret_d    = S_RW;
        state_d  = (T_RCD > 1) ? S_WAIT : S_RW;
      end
      S_RW: state_d = S_IDLE;
      S_PREA: begin
        dly_load = 1'b1;
        dly_val  = wait_load(T_RP);
        ret_d    = S_REF;
        state_d  = (T_RP > 1) ? S_WAIT : S_REF;
      end
      S_REF: begin
        dly_load = 1'b1;
        dly_val  = wait_load(T_RFC);
        ret_d    = S_IDLE;
        state_d  = (T_RFC > 1) ? S_WAIT : S_IDLE;
      end
      S_WAIT: if (dly_expired) state_d = ret_q;
      default: state_d = S_IDLE;
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      ret_q   <= S_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      ret_q   <= ret_d;
      done_q  <= (state_q == S_RW);
    end
  end

  // request latch with written-out enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= 1'b0;
      bank_q <= '0;
      row_q  <= '0;
      col_q  <= '0;
    end else if (lat_en) begin
      wr_q   <= req_write;
      bank_q <= req_bank;
      row_q  <= req_row;
      col_q  <= req_col;
    end
  end

  // command output decode
  always_comb begin
    cmd_d    = CMD_NOP;
    cmd_bank = '0;
    cmd_addr = '0;
    unique case (state_q)
      S_PRE: begin
        cmd_d    = CMD_PRE;
        cmd_bank = bank_q;
      end
      S_ACT: begin
        cmd_d    = CMD_ACT;
        cmd_bank = bank_q;
        cmd_addr = ADDR_W'(row_q);
      end
      S_RW: begin
        cmd_d    = wr_q ? CMD_WR : CMD_RD;
        cmd_bank = bank_q;
        cmd_addr = ADDR_W'(col_q);
      end
      S_PREA:  cmd_d = CMD_PREA;
      S_REF:   cmd_d = CMD_REF;
      default: cmd_d = CMD_NOP;
    endcase
  end

  assign cmd_code  = cmd_d;
  assign cmd_valid = (cmd_d != CMD_NOP);
  assign req_ready = (state_q == S_IDLE) && !ref_pending;
  assign done      = done_q;

endmodule

// File: rtl/sdram_row_seq_chk.sv
module sdram_row_seq_chk
  import sdram_seq_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int T_RP      = 3,
  parameter int T_RCD     = 3,
  parameter int T_RFC     = 8,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              cmd_valid,
  input logic [2:0]        cmd_code,
  input logic [BANK_W-1:0] cmd_bank,
  input logic              done
);

  localparam logic [7:0] SAT   = 8'hFF;
  localparam logic [7:0] RP8   = 8'(T_RP);
  localparam logic [7:0] RCD8  = 8'(T_RCD);
  localparam logic [7:0] RFC8  = 8'(T_RFC);

  logic is_act, is_rw, is_pre, is_prea, is_ref;
  assign is_act  = cmd_valid && (cmd_code == CMD_ACT);
  assign is_rw   = cmd_valid && ((cmd_code == CMD_RD) || (cmd_code == CMD_WR));
  assign is_pre  = cmd_valid && (cmd_code == CMD_PRE);
  assign is_prea = cmd_valid && (cmd_code == CMD_PREA);
  assign is_ref  = cmd_valid && (cmd_code == CMD_REF);

  logic [7:0] since_pre, since_prea, since_act, since_ref;
  logic [NUM_BANKS-1:0] sh_open;

  function automatic logic [7:0] bump(input logic [7:0] v);
    return (v == SAT) ? SAT : v + 8'd1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_pre  <= SAT;
      since_prea <= SAT;
      since_act  <= SAT;
      since_ref  <= SAT;
      sh_open    <= '0;
    end else begin
      since_pre  <= (is_pre || is_prea) ? 8'd1 : bump(since_pre);
      since_prea <= is_prea ? 8'd1 : bump(since_prea);
      since_act  <= is_act ? 8'd1 : bump(since_act);
      since_ref  <= is_ref ? 8'd1 : bump(since_ref);
      if (is_prea)     sh_open <= '0;
      else if (is_pre) sh_open[cmd_bank] <= 1'b0;
      else if (is_act) sh_open[cmd_bank] <= 1'b1;
    end
  end

  a_r1_rw_needs_open: assert property (@(posedge clk) disable iff (!rst_n)
    is_rw |-> sh_open[cmd_bank]);

  a_r1_act_needs_closed: assert property (@(posedge clk) disable iff (!rst_n)
    is_act |-> !sh_open[cmd_bank]);

  a_r3_rcd_gap: assert property (@(posedge clk) disable iff (!rst_n)
    is_rw |-> (since_act >= RCD8));

  a_r4_rp_gap: assert property (@(posedge clk) disable iff (!rst_n)
    is_act |-> (since_pre >= RP8));

  a_r6_done_after_rw: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(is_rw));

  a_r7_ref_after_prea: assert property (@(posedge clk) disable iff (!rst_n)
    is_ref |-> (since_prea == RP8));

  a_r8_refresh_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ((since_ref >= 8'd1) && (since_ref < RFC8)) |-> (!cmd_valid && !req_ready));

  a_r10_ready_no_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !cmd_valid);

  a_r10_nop_code: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |-> (cmd_code == CMD_NOP));

endmodule

bind sdram_row_seq sdram_row_seq_chk #(
  .NUM_BANKS(NUM_BANKS),
  .T_RP     (T_RP),
  .T_RCD    (T_RCD),
  .T_RFC    (T_RFC)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_ready(req_ready),
  .cmd_valid(cmd_valid),
  .cmd_code (cmd_code),
  .cmd_bank (cmd_bank),
  .done     (done)
);

// File: tb/test_sdram_row_seq.sv
module test_sdram_row_seq;

  localparam int T_RP  = 2;
  localparam int T_RCD = 3;
  localparam int T_RFC = 5;
  localparam int REF_I = 600;

  localparam int HIT = 0, EMPTY = 1, MISS = 2;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic        req_write;
  logic [1:0]  req_bank;
  logic [12:0] req_row;
  logic [9:0]  req_col;
  logic        cmd_valid;
  logic [2:0]  cmd_code;
  logic [1:0]  cmd_bank;
  logic [12:0] cmd_addr;
  logic        done;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit finished = 0;

  sdram_row_seq #(
    .T_RP(T_RP), .T_RCD(T_RCD), .T_RFC(T_RFC), .REF_INTERVAL(REF_I)
  ) i_sdram_row_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_bank(cmd_bank),
    .cmd_addr(cmd_addr), .done(done)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // {write, bank[1:0], row[12:0], col[9:0], class[1:0]}
  localparam logic [27:0] VEC [12] = '{
    {1'b0, 2'd0, 13'd5,    10'd3,    2'd1},  // R3 empty bank 0
    {1'b0, 2'd1, 13'd7,    10'd4,    2'd1},  // R3 empty bank 1
    {1'b1, 2'd0, 13'd5,    10'd10,   2'd0},  // R5 bank 0 kept open
    {1'b0, 2'd0, 13'd9,    10'd11,   2'd2},  // R4 miss bank 0
    {1'b0, 2'd1, 13'd7,    10'd12,   2'd0},  // R5 bank 1 survives miss
    {1'b1, 2'd0, 13'd9,    10'd1023, 2'd0},  // R12 top column
    {1'b1, 2'd2, 13'd0,    10'd0,    2'd1},  // R3 bank 2
    {1'b0, 2'd3, 13'd8191, 10'd5,    2'd1},  // R12 top row
    {1'b0, 2'd2, 13'd1,    10'd6,    2'd2},  // R4 miss bank 2
    {1'b1, 2'd3, 13'd8191, 10'd7,    2'd0},  // R2 hit bank 3
    {1'b0, 2'd0, 13'd8191, 10'd8,    2'd2},  // R4 miss to top row
    {1'b0, 2'd1, 13'd7,    10'd9,    2'd0}   // R5 bank 1 still hit
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_req(input logic wr, input logic [1:0] b, input logic [12:0] r,
                         input logic [9:0] c, input int cls, input string tag,
                         output int first_cyc);
    int          ncmd;
    int          done_at;
    int          n_exp;
    int          at_c [4];
    logic [2:0]  code_c [4];
    logic [1:0]  bank_c [4];
    logic [12:0] addr_c [4];
    logic [2:0]  ec [3];
    int          ea [3];
    logic [2:0]  rwc;
    req_write = wr; req_bank = b; req_row = r; req_col = c; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    first_cyc = cyc;
    ncmd = 0; done_at = -1;
    for (int t = 1; t <= 40; t++) begin
      if (t > 1) @(negedge clk);
      if (cmd_valid && ncmd < 4) begin
        code_c[ncmd] = cmd_code; bank_c[ncmd] = cmd_bank;
        addr_c[ncmd] = cmd_addr; at_c[ncmd] = t; ncmd++;
      end
      if (done) begin done_at = t; break; end
    end
    rwc = wr ? 3'd3 : 3'd2;
    ec[0] = 3'd0; ec[1] = 3'd0; ec[2] = 3'd0; ea[0] = 0; ea[1] = 0; ea[2] = 0;
    case (cls)
      HIT:   begin n_exp = 1; ec[0] = rwc; ea[0] = 1; end
      EMPTY: begin n_exp = 2; ec[0] = 3'd1; ea[0] = 1; ec[1] = rwc; ea[1] = 1 + T_RCD; end
      default: begin
        n_exp = 3; ec[0] = 3'd4; ea[0] = 1; ec[1] = 3'd1; ea[1] = 1 + T_RP;
        ec[2] = rwc; ea[2] = 1 + T_RP + T_RCD;
      end
    endcase
    chk(ncmd == n_exp, {tag, " R1 R2 R3 R4 command count"}, ncmd, n_exp);
    for (int i = 0; i < n_exp && i < ncmd; i++) begin
      chk(code_c[i] == ec[i], {tag, " R2 R3 R4 command code"}, int'(code_c[i]), int'(ec[i]));
      chk(at_c[i] == ea[i], {tag, " R3 R4 command cycle"}, at_c[i], ea[i]);
      chk(bank_c[i] == b, {tag, " R12 bank field"}, int'(bank_c[i]), int'(b));
      if (ec[i] == 3'd1)
        chk(addr_c[i] == r, {tag, " R3 R12 row on ACTIVE"}, int'(addr_c[i]), int'(r));
      if (ec[i] == rwc)
        chk(addr_c[i] == 13'(c), {tag, " R3 R12 column on access"}, int'(addr_c[i]), int'(c));
    end
    chk(done_at == ea[n_exp-1] + 1, {tag, " R6 done timing"}, done_at, ea[n_exp-1] + 1);
    @(negedge clk);
    chk(!done, {tag, " R6 done one cycle"}, int'(done), 0);
  endtask

  task automatic wait_prea();
    while (!(cmd_valid && cmd_code == 3'd5)) @(negedge clk);
  endtask

  initial begin
    int fc, ka, kb, kp;
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_bank = '0; req_row = '0; req_col = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(req_ready == 1'b1, "R11 ready in reset", int'(req_ready), 1);
    chk(cmd_valid == 1'b0, "R11 no command in reset", int'(cmd_valid), 0);
    chk(done == 1'b0, "R11 done low in reset", int'(done), 0);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(!cmd_valid && cmd_code == 3'd0, "R10 idle NOP", int'(cmd_code), 0);
      chk(req_ready, "R11 ready after reset", int'(req_ready), 1);
    end

    // table-driven phase: finishes well before the first refresh
    for (int v = 0; v < 12; v++) begin
      run_req(VEC[v][27], VEC[v][26:25], VEC[v][24:12], VEC[v][11:2],
              int'(VEC[v][1:0]), $sformatf("vec%0d", v), fc);
      if (v == 0) chk(fc > 0, "R2 request accepted", fc, 1);
    end

    // refresh sequence
    wait_prea();
    ka = cyc;
    chk(!req_ready, "R8 ready low at PRECHARGE-ALL", int'(req_ready), 0);
    for (int k = 1; k <= T_RP + T_RFC; k++) begin
      @(negedge clk);
      if (k == T_RP)
        chk(cmd_valid && cmd_code == 3'd6, "R7 AUTO-REFRESH after T_RP", int'(cmd_code), 6);
      else if (k < T_RP + T_RFC)
        chk(!cmd_valid, "R8 no command during refresh", int'(cmd_code), 0);
      if (k < T_RP + T_RFC)
        chk(!req_ready, "R8 ready low during refresh", int'(req_ready), 0);
      else
        chk(req_ready, "R8 ready back after T_RFC", int'(req_ready), 1);
    end

    // R7: refresh closed bank 1, so its former row needs ACTIVE again
    run_req(1'b0, 2'd1, 13'd7, 10'd20, EMPTY, "R7 closed after refresh", fc);

    wait_prea();
    kb = cyc;
    chk(kb - ka == REF_I, "R7 refresh period", kb - ka, REF_I);

    // R9 case 1: accepted two cycles before refresh is due, completes first
    while (cyc < kb + REF_I - 2) @(negedge clk);
    chk(req_ready, "R9 ready before refresh due", int'(req_ready), 1);
    run_req(1'b0, 2'd1, 13'd7, 10'd21, EMPTY, "R9 in-flight request", fc);
    wait_prea();
    kp = kb + REF_I + 1 + T_RCD;
    chk(cyc == kp, "R9 refresh after in-flight done", cyc, kp);

    // R9 case 2: request presented when refresh pending, waits it out
    while (cyc < kb + 2 * REF_I - 1) @(negedge clk);
    chk(!req_ready, "R9 ready low while refresh pending", int'(req_ready), 0);
    run_req(1'b1, 2'd2, 13'd3, 10'd22, EMPTY, "R9 held request", fc);
    chk(fc == kb + 2 * REF_I + T_RP + T_RFC + 1, "R9 held until refresh ends",
        fc, kb + 2 * REF_I + T_RP + T_RFC + 1);

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule